// File: doc/BRIEF.md
# Lane-Group Memory Access Coalescer

The block accepts one memory request for a whole group of 32 lanes: one byte address per lane, a mask of active lanes and a load/store flag. It turns that request into the smallest set of naturally aligned memory transactions. Each transaction is 32 bytes or 128 bytes wide. Each goes out on a valid/ready request port with a base address, a size code and a mask of the lanes it serves.

Active lanes are grouped by the 128-byte segment their address falls in. If all lanes of a segment fall within one 32-byte sector of it, that segment is fetched as one 32-byte transaction. Otherwise it is fetched as one 128-byte transaction covering the whole segment. Segments are issued from the lowest address to the highest, at most one per clock. While the downstream port is not ready, the current transaction is held unchanged. The input side stays not-ready from the moment a request is taken until its last transaction has been accepted.

Top module: `lane_coalescer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A request is taken on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 until the cycle after the edge that accepts the request's last transaction. A request with no active lane is taken and produces no transaction.
- R3: `out_size` is 0 for a 32-byte transaction and 1 for a 128-byte one. `out_base` is a multiple of the transaction size.
- R4: Segment number is address bits [31:7] and sector number is bits [6:5]. If every active lane in a segment shares one sector, the segment is issued as a 32-byte transaction at that sector's base.
- R5: A segment whose active lanes span two or more sectors is issued as one 128-byte transaction at the segment base.
- R6: A request produces exactly one transaction per distinct segment among its active lanes.
- R7: Within a request, transactions are issued in strictly ascending base address order.
- R8: Bit i of `out_mask` is set exactly when lane i is active and its address lies in the transaction. The masks of one request are disjoint, and together they equal the active mask.
- R9: Addresses of inactive lanes do not affect any transaction.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output fields hold steady. When `out_ready` stays 1, one transaction is accepted per cycle with no gap.
- R11: `out_store` equals the `in_store` value captured with the request, on every transaction.
- R12: The first transaction of a request appears on the cycle after the request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A lane-group request is offered |
| in_ready | output | 1 | Block can take a request |
| in_store | input | 1 | 1 for a store request, 0 for a load |
| in_active | input | 32 | Active-lane mask, bit i for lane i |
| in_addr | input | 1024 | Lane byte addresses, lane i at bits [32*i+31:32*i] |
| out_valid | output | 1 | A transaction is offered |
| out_ready | input | 1 | Downstream takes the transaction |
| out_store | output | 1 | Load/store flag of the request |
| out_base | output | 32 | Aligned base byte address |
| out_size | output | 1 | 0 = 32 bytes, 1 = 128 bytes |
| out_mask | output | 32 | Lanes served by this transaction |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32-bit addresses, 128-byte segments and 32-byte sectors. With these, the lane-to-segment tree has five full levels. Every segment can hold four distinct sectors, so both size choices and single-sector collapse of wide segments are reachable. Stimulus covers contiguous and misaligned word streams, 128-byte strides fed in descending lane order, a broadcast address, empty and sparse masks with junk in idle lanes, and random addresses confined to a few segments. All of it runs under steady, periodic and random downstream backpressure.

// File: rtl/coal_pkg.sv
// Shared types for the lane-group coalescer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package coal_pkg;

    // Transaction width code as driven on the request port.
    typedef enum logic {
        SZ_SECTOR  = 1'b0,
        SZ_SEGMENT = 1'b1
    } coal_size_e;

    // Sequencer state: idle and able to take a request, or issuing.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } coal_state_e;

endpackage

// File: rtl/coal_seg_min.sv
// Finds the lowest segment number among the pending lanes.
// A balanced comparison tree is used, with the lane count padded to a power of two.
// Assumes SEG_LG < ADDR_W. Padding leaves are never valid.
module coal_seg_min #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    parameter int SEG_LG = 7,
    localparam int SEG_W = ADDR_W - SEG_LG
) (
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    input  logic [LANES-1:0]        pend,
    output logic [SEG_W-1:0]        min_seg,
    output logic                    any_pend
);
    localparam int LG = (LANES > 1) ? $clog2(LANES) : 0;
    localparam int P  = 1 << LG;

    for (genvar l = 0; l <= LG; l++) begin : g_lvl
        localparam int W = P >> l;
        logic [SEG_W-1:0] seg [W];
        logic             vld [W];
        for (genvar k = 0; k < W; k++) begin : g_node
            if (l == 0) begin : g_leaf
                if (k < LANES) begin : g_real
                    // Leaf: the lane's segment number, valid when still pending.
                    assign seg[k] = lane_addr[k*ADDR_W+SEG_LG +: SEG_W];
                    assign vld[k] = pend[k];
                end else begin : g_pad
                    assign seg[k] = '0;
                    assign vld[k] = 1'b0;
                end
            end else begin : g_inner
                logic pick_a;
                // Inner node: keep the smaller valid child, left child on a tie.
                assign pick_a = g_lvl[l-1].vld[2*k] &&
                                (!g_lvl[l-1].vld[2*k+1] ||
                                 (g_lvl[l-1].seg[2*k] <= g_lvl[l-1].seg[2*k+1]));
                assign seg[k] = pick_a ? g_lvl[l-1].seg[2*k] : g_lvl[l-1].seg[2*k+1];
                assign vld[k] = g_lvl[l-1].vld[2*k] || g_lvl[l-1].vld[2*k+1];
            end
        end
    end

    assign min_seg  = g_lvl[LG].seg[0];
    assign any_pend = g_lvl[LG].vld[0];
endmodule

// File: rtl/coal_group.sv
// Builds the transaction for the chosen segment: lane mask, size and base.
// The size is 32 bytes when the member lanes occupy a single sector, 128 otherwise.
// Assumes SECT_LG < SEG_LG < ADDR_W and that min_seg belongs to a pending lane.
module coal_group
    import coal_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int ADDR_W  = 32,
    parameter int SEG_LG  = 7,
    parameter int SECT_LG = 5,
    localparam int SEG_W  = ADDR_W - SEG_LG,
    localparam int SECT_W = SEG_LG - SECT_LG,
    localparam int SECTS  = 1 << SECT_W
) (
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    input  logic [LANES-1:0]        pend,
    input  logic [SEG_W-1:0]        min_seg,
    output logic [LANES-1:0]        grp_mask,
    output logic [ADDR_W-1:0]       grp_base,
    output coal_size_e              grp_size
);
    logic [SECT_W-1:0] lane_sect [LANES];
    logic [SECTS-1:0]  sect_any;
    logic [SECT_W-1:0] sect_idx;
    logic              one_sect;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Lane membership: pending and in the chosen segment.
        assign grp_mask[i]  = pend[i] &&
                              (lane_addr[i*ADDR_W+SEG_LG +: SEG_W] == min_seg);
        assign lane_sect[i] = lane_addr[i*ADDR_W+SECT_LG +: SECT_W];
    end

    for (genvar s = 0; s < SECTS; s++) begin : g_sect
        logic [LANES-1:0] in_s;
        for (genvar i = 0; i < LANES; i++) begin : g_hit
            assign in_s[i] = grp_mask[i] && (lane_sect[i] == SECT_W'(s));
        end
        // Sector presence: some member lane falls in sector s.
        assign sect_any[s] = |in_s;
    end

    // Encode the lowest present sector; it is the only one when one_sect holds.
    always_comb begin
        sect_idx = '0;
        for (int s = SECTS - 1; s >= 0; s--) begin
            if (sect_any[s]) sect_idx = SECT_W'(s);
        end
    end

    assign one_sect = $onehot(sect_any);

    // Size and aligned base of the transaction.
    always_comb begin
        if (one_sect) begin
            grp_size = SZ_SECTOR;
            grp_base = {min_seg, sect_idx, {SECT_LG{1'b0}}};
        end else begin
            grp_size = SZ_SEGMENT;
            grp_base = {min_seg, {SEG_LG{1'b0}}};
        end
    end
endmodule

// File: rtl/coal_seq.sv
// Holds the captured request and steps through its segments.
// Lanes are removed from the pending mask as each transaction is accepted.
// Assumes grp_mask is a non-empty subset of pend whenever pend is non-empty.
module coal_seq
    import coal_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_store,
    input  logic [LANES-1:0]        in_active,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]        grp_mask,
    input  logic                    out_ready,
    output logic                    out_valid,
    output logic                    out_store,
    output logic                    last_txn,
    output logic [LANES-1:0]        pend,
    output logic [LANES*ADDR_W-1:0] addr_q
);
    coal_state_e      state;
    logic [LANES-1:0] pend_next;

    // Lanes still owed a transaction after the current one is accepted.
    assign pend_next = pend & ~grp_mask;
    assign last_txn  = (pend_next == '0);
    assign in_ready  = (state == ST_IDLE);
    assign out_valid = (state == ST_ISSUE);

    // Capture requests and retire lanes on each accepted transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pend      <= '0;
            out_store <= 1'b0;
            addr_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        addr_q    <= in_addr;
                        out_store <= in_store;
                        pend      <= in_active;
                        state     <= (|in_active) ? ST_ISSUE : ST_IDLE;
                    end
                end
                ST_ISSUE: begin
                    if (out_ready) begin
                        pend <= pend_next;
                        if (last_txn) state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: the offered mask serves only pending lanes and is never empty.
    a_r8_mask_subset: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((grp_mask & ~pend) == '0) && (grp_mask != '0));

    // R2: the block stays busy until its final transaction is accepted.
    a_r2_busy_until_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && last_txn)) |=> (out_valid && !in_ready));

    // R12: a non-empty request is offered on the following cycle.
    a_r12_first_next: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_active != '0)) |=> out_valid);
endmodule

// File: rtl/lane_coalescer.sv
// Top of the lane-group coalescer: merges 32 lane addresses into aligned
// 32-byte or 128-byte transactions, one per cycle in ascending address order.
// Assumes lane addresses are byte addresses of accesses that stay inside one sector.
module lane_coalescer
    import coal_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int ADDR_W  = 32,
    parameter int SEG_LG  = 7,
    parameter int SECT_LG = 5,
    localparam int SEG_W  = ADDR_W - SEG_LG
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_store,
    input  logic [LANES-1:0]        in_active,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic                    out_store,
    output logic [ADDR_W-1:0]       out_base,
    output logic                    out_size,
    output logic [LANES-1:0]        out_mask
);
    logic [LANES-1:0]        pend;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [SEG_W-1:0]        min_seg;
    logic                    any_pend;
    logic                    last_txn;
    coal_size_e              grp_size;

    coal_seq #(.LANES(LANES), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_store  (in_store),
        .in_active (in_active),
        .in_addr   (in_addr),
        .grp_mask  (out_mask),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_store (out_store),
        .last_txn  (last_txn),
        .pend      (pend),
        .addr_q    (addr_q)
    );

    coal_seg_min #(.LANES(LANES), .ADDR_W(ADDR_W), .SEG_LG(SEG_LG)) u_min (
        .lane_addr (addr_q),
        .pend      (pend),
        .min_seg   (min_seg),
        .any_pend  (any_pend)
    );

    coal_group #(.LANES(LANES), .ADDR_W(ADDR_W), .SEG_LG(SEG_LG),
                 .SECT_LG(SECT_LG)) u_grp (
        .lane_addr (addr_q),
        .pend      (pend),
        .min_seg   (min_seg),
        .grp_mask  (out_mask),
        .grp_base  (out_base),
        .grp_size  (grp_size)
    );

    assign out_size = grp_size;

    // R2: an offered transaction always has a pending lane behind it.
    a_r2_valid_has_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> any_pend);

    // R3: the base is aligned to the transaction size.
    a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_size ? (out_base[SEG_LG-1:0] == '0)
                                : (out_base[SECT_LG-1:0] == '0)));

    // R10: a stalled transaction does not change.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_base) &&
                                       $stable(out_mask) && $stable(out_size) &&
                                       $stable(out_store)));

    // R7: the next transaction of the same request is at a higher address.
    a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !last_txn) |=> (out_base > $past(out_base)));
endmodule

// File: tb/lane_coalescer_bench.sv
// Self-checking bench for lane_coalescer. A behavioural model builds the
// expected transaction queue per request and is compared every clock.
module lane_coalescer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 32;

    typedef struct {
        logic [31:0] base;
        logic        size;
        logic [31:0] mask;
        logic        store;
    } txn_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_store = 1'b0;
    logic [31:0]   in_active = '0;
    logic [1023:0] in_addr;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic          out_store;
    logic [31:0]   out_base;
    logic          out_size;
    logic [31:0]   out_mask;

    logic [31:0] lane_a [NL];
    int          checks = 0;
    int          errors = 0;
    int          rdy_mode = 0;
    bit          done = 0;

    txn_t        expq [$];
    logic [31:0] req_active;
    int          req_nseg;
    logic [31:0] seen_union;
    bit          seen_overlap;
    int          seen_cnt;
    logic [31:0] last_base;
    bit          have_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NL; i++) in_addr[i*32 +: 32] = lane_a[i];
    end

    lane_coalescer u_lane_coalescer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_store(in_store), .in_active(in_active), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_store(out_store),
        .out_base(out_base), .out_size(out_size), .out_mask(out_mask)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected transactions, built from the requirement text.
    task automatic build(input logic [31:0] act, input logic st);
        logic [31:0] left = act;
        logic [24:0] segs [$];
        req_nseg = 0;
        for (int i = 0; i < NL; i++) begin
            if (act[i]) begin
                bit found = 0;
                foreach (segs[k]) if (segs[k] == lane_a[i][31:7]) found = 1;
                if (!found) segs.push_back(lane_a[i][31:7]);
            end
        end
        req_nseg = segs.size();
        while (left != 0) begin
            logic [24:0] lo = '1;
            logic [31:0] m = '0;
            logic [3:0]  sec = '0;
            txn_t t;
            for (int i = 0; i < NL; i++)
                if (left[i] && lane_a[i][31:7] < lo) lo = lane_a[i][31:7];
            for (int i = 0; i < NL; i++)
                if (left[i] && lane_a[i][31:7] == lo) begin
                    m[i] = 1'b1;
                    sec[lane_a[i][6:5]] = 1'b1;
                end
            t.mask = m;
            t.store = st;
            if ($countones(sec) == 1) begin
                t.size = 1'b0;
                t.base = {lo, 7'b0};
                for (int s = 0; s < 4; s++) if (sec[s]) t.base[6:5] = 2'(s);
            end else begin
                t.size = 1'b1;
                t.base = {lo, 7'b0};
            end
            expq.push_back(t);
            left &= ~m;
        end
        req_active = act;
        seen_union = '0;
        seen_overlap = 0;
        seen_cnt = 0;
        have_last = 0;
    endtask

    // Per-clock comparison of the ports against the model, then model update.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(in_ready == (expq.size() == 0), "R2", "in_ready",
                  {31'b0, in_ready}, {31'b0, expq.size() == 0});
            check(out_valid == (expq.size() != 0), "R12", "out_valid",
                  {31'b0, out_valid}, {31'b0, expq.size() != 0});
            if (out_valid && expq.size() != 0) begin
                check(out_base == expq[0].base, "R4", "out_base", out_base, expq[0].base);
                check(out_size == expq[0].size, "R5", "out_size",
                      {31'b0, out_size}, {31'b0, expq[0].size});
                check(out_mask == expq[0].mask, "R8", "out_mask", out_mask, expq[0].mask);
                check(out_store == expq[0].store, "R11", "out_store",
                      {31'b0, out_store}, {31'b0, expq[0].store});
                check(out_size ? (out_base[6:0] == 0) : (out_base[4:0] == 0),
                      "R3", "alignment", out_base, 32'h0);
                if (out_ready) begin
                    if (have_last)
                        check(out_base > last_base, "R7", "ascending", out_base, last_base);
                    last_base = out_base;
                    have_last = 1;
                    if ((seen_union & out_mask) != 0) seen_overlap = 1;
                    seen_union |= out_mask;
                    seen_cnt++;
                    void'(expq.pop_front());
                    if (expq.size() == 0) begin
                        check(seen_union == req_active, "R8", "mask union",
                              seen_union, req_active);
                        check(!seen_overlap, "R8", "mask overlap",
                              {31'b0, seen_overlap}, 32'h0);
                        check(seen_cnt == req_nseg, "R6", "transaction count",
                              seen_cnt, req_nseg);
                    end
                end
            end
            if (in_valid && in_ready) build(in_active, in_store);
        end
    end

    // Downstream ready pattern: steady, random, or one cycle in four.
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            case (rdy_mode)
                0: out_ready = 1'b1;
                1: out_ready = 1'($urandom % 2);
                default: out_ready = (cyc % 4 == 0);
            endcase
        end
    end

    task automatic send(input logic [31:0] act, input logic st);
        @(posedge clk);
        #1;
        in_active = act;
        in_store = st;
        in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        for (int i = 0; i < NL; i++) lane_a[i] = $urandom;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=drained");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NL; i++) lane_a[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "reset in_ready", {31'b0, in_ready}, 32'h1);
        check(out_valid == 1'b0, "R1", "reset out_valid", {31'b0, out_valid}, 32'h0);

        for (int m = 0; m < 3; m++) begin
            rdy_mode = m;
            // R5: contiguous words on an aligned segment give one 128-byte access.
            for (int i = 0; i < NL; i++) lane_a[i] = 32'h0000_1000 + 4*i;
            send('1, 1'b0);
            // R4: eight lanes inside one sector give one 32-byte access.
            for (int i = 0; i < NL; i++) lane_a[i] = (i < 8) ? 32'h0000_2040 + 4*i : $urandom;
            send(32'h0000_00FF, 1'b1);
            // R7: 128-byte stride, lanes in descending address order.
            for (int i = 0; i < NL; i++) lane_a[i] = 32'h0010_0000 + 128*(NL-1-i) + 8;
            send('1, 1'b1);
            // R6: misaligned contiguous words straddle two segments.
            for (int i = 0; i < NL; i++) lane_a[i] = 32'h0000_3040 + 4*i;
            send('1, 1'b0);
            // R4: every lane at one address.
            for (int i = 0; i < NL; i++) lane_a[i] = 32'hFFFF_FFE4;
            send('1, 1'b0);
            // R2: an empty request yields nothing and frees the input at once.
            send('0, 1'b1);
            // R9: sparse mask, idle lanes carry junk addresses.
            for (int i = 0; i < NL; i++) lane_a[i] = (i % 5 == 0) ? 32'h0000_8000 + 32*(i % 3) : $urandom;
            send(32'h4210_8421, 1'b0);
            // R10: random addresses within four segments.
            for (int r = 0; r < 20; r++) begin
                for (int i = 0; i < NL; i++)
                    lane_a[i] = 32'h0004_0000 + (($urandom % 4) << 7) + (($urandom % 32) << 2);
                send($urandom, 1'($urandom % 2));
            end
        end

        // R9: the same active lanes with different idle-lane addresses give the same result.
        rdy_mode = 0;
        for (int i = 0; i < NL; i++) lane_a[i] = (i < 2) ? 32'h0000_9000 + 64*i : 32'h0;
        send(32'h3, 1'b0);
        for (int i = 0; i < NL; i++) lane_a[i] = (i < 2) ? 32'h0000_9000 + 64*i : 32'hDEAD_BEE0 + i;
        send(32'h3, 1'b0);
        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule